// File: doc/BRIEF.md
# Rectangle Copy Blitter

This block is a DMA copy engine. It moves a rectangle of bytes from a paged sprite memory into one of two 128x128 byte framebuffers, one pixel per clock. A CPU sets it up through eight byte-wide write-only registers: destination X and Y, source X and Y, width, height, start and fill colour. The rest of the configuration comes in as level mode inputs: enable, colour fill, tile carry, opaque, IRQ enable, per-axis clipping, sprite page and framebuffer select. Both memories sit outside the block. The block issues registered read requests to sprite memory and registered write strobes to the framebuffer.

The copy walks the rectangle in row-major order. Each source coordinate comes from an 8-bit counter. Tile carry can stop the carry from the counter's low nibble into its high nibble, so a 16x16 tile repeats. A flip bit can invert the counter's output. Destination writes wrap around the 128-pixel screen, or are dropped when the clip flag for that axis is set. Zero-valued bytes count as transparent unless opaque mode is on. When a copy finishes, a level interrupt is raised. It stays high until the start register is written again.

Top module: `rect_blitter`

## Requirements
- R1: The register offsets are 0 destination X, 1 destination Y, 2 source X, 3 source Y, 4 width, 5 height, 6 start and 7 colour. A write is taken only while `en` is high. A write while `en` is low changes nothing, and a start write while `en` is low neither starts a copy nor clears the IRQ.
- R2: Every write to offset 6 clears `irq`. When bit 0 of the written value is 1 the write also starts a copy. When bit 0 is 0 no copy starts.
- R3: Width bits 6:0 times height bits 6:0 give the pixel count. `busy` is high for exactly that many cycles after the start write, and one sprite read is issued per busy cycle. If either size is 0, no pixel is copied, `busy` stays low and completion is still signalled.
- R4: Width bit 7 replaces source X with its bitwise inverse. Height bit 7 does the same for source Y.
- R5: With `tile_carry` low, source X is (X0 & 0xF0) | ((X0 + column) & 0x0F), and source Y follows the same rule with the row. With `tile_carry` high, source X is X0 + column and source Y is Y0 + row, both modulo 256.
- R6: With `opaque` low, no pixel whose value is zero is written. With `opaque` high, zero-valued pixels are written.
- R7: With `fill_mode` high, the colour register is written in place of sprite data. The R6 rule still applies to that value.
- R8: Destination X is (DX + column) mod 256, and the pixel is stored at bits 6:0 of that sum. If `clip_x` is high and bit 7 of the sum is 1, the write is dropped. Y follows the same rules with `clip_y`.
- R9: `spr_addr` = {page_sel, srcY, srcX}, 19 bits. `fb_addr` = {fb_sel, y[6:0], x[6:0]}, 15 bits. Sprite data is expected on `spr_rdata` one cycle after `spr_re`.
- R10: When a copy completes with `irq_en` high, `irq` rises on the same edge as the final framebuffer write and stays high until the next start write. With `irq_en` low, `irq` stays low.
- R11: A start write during a copy restarts the copy from the current register values. `busy` then stays high for the full new pixel count.
- R12: The engine never changes a parameter register, so a start write alone repeats the previous copy.
- R13: Sprite reads come in row-major order: rows from top to bottom, columns from left to right, with source X reloaded at the start of each row.
- R14: After reset, `busy`, `irq`, `spr_re` and `fb_we` are low and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Blitter enable; register writes are accepted only while high |
| fill_mode | input | 1 | Write the colour register instead of sprite data |
| tile_carry | input | 1 | Allow carry from the low nibble into the high nibble of the source counters |
| opaque | input | 1 | Also write zero-valued pixels |
| irq_en | input | 1 | Raise `irq` when a copy completes |
| clip_x | input | 1 | Drop writes outside 0-127 in X instead of wrapping |
| clip_y | input | 1 | Drop writes outside 0-127 in Y instead of wrapping |
| page_sel | input | 3 | Sprite memory page |
| fb_sel | input | 1 | Target framebuffer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| spr_re | output | 1 | Sprite memory read request |
| spr_addr | output | 19 | Sprite memory read address |
| spr_rdata | input | 8 | Sprite read data, one cycle after the request |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | 15 | Framebuffer write address |
| fb_wdata | output | 8 | Framebuffer write data |
| busy | output | 1 | A copy is issuing pixels |
| irq | output | 1 | Level completion interrupt |

## Verification
The assertions check several rules on every cycle:
- a copy can only begin after an enabled start write with bit 0 set;
- every busy cycle is followed by a sprite read;
- `irq` rises only while enabled and falls only after a start write;
- no zero byte reaches the framebuffer in transparent mode;
- fill writes carry the colour register.

Other behaviour only shows in the framebuffer image, which the bench compares against an arithmetic model:
- the source address sequence under flip and tile repeat;
- wrapping and clipping at the screen edges;
- restart;
- zero-size copies;
- repeated copies that need only a start write.

A sweep over all 128 combinations of the mode and flip flags, with sizes and positions chosen to cross the edges, covers both the image and the read order.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [2:0] {
    OFS_DST_X  = 3'd0,
    OFS_DST_Y  = 3'd1,
    OFS_SRC_X  = 3'd2,
    OFS_SRC_Y  = 3'd3,
    OFS_WIDTH  = 3'd4,
    OFS_HEIGHT = 3'd5,
    OFS_START  = 3'd6,
    OFS_COLOR  = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dst_x,
  output logic [DATA_W-1:0] dst_y,
  output logic [DATA_W-1:0] src_x,
  output logic [DATA_W-1:0] src_y,
  output logic [DATA_W-1:0] size_w,
  output logic [DATA_W-1:0] size_h,
  output logic [DATA_W-1:0] color,
  output logic              start_wr,
  output logic              start_go
);
  import blit_pkg::*;

  // R2: any enabled write to the start offset; bit 0 selects a real start
  assign start_wr = en && we && (reg_ofs_e'(addr) == OFS_START);
  assign start_go = start_wr && wdata[0];

  // R1 / R12: parameter storage, written only by the CPU side
  always_ff @(posedge clk) begin
    if (rst) begin
      dst_x  <= '0;
      dst_y  <= '0;
      src_x  <= '0;
      src_y  <= '0;
      size_w <= '0;
      size_h <= '0;
      color  <= '0;
    end else if (en && we) begin
      case (reg_ofs_e'(addr))
        OFS_DST_X:  dst_x  <= wdata;
        OFS_DST_Y:  dst_y  <= wdata;
        OFS_SRC_X:  src_x  <= wdata;
        OFS_SRC_Y:  src_y  <= wdata;
        OFS_WIDTH:  size_w <= wdata;
        OFS_HEIGHT: size_h <= wdata;
        OFS_COLOR:  color  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blit_src_axis.sv
module blit_src_axis #(
  parameter int W      = 8,
  parameter int TILE_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         carry,
  input  logic         flip,
  input  logic [W-1:0] init,
  output logic [W-1:0] coord
);
  localparam logic [W-1:0]      ONE_W = W'(1);
  localparam logic [TILE_W-1:0] ONE_T = TILE_W'(1);

  logic [W-1:0] cnt;
  logic [W-1:0] nxt;

  // R5: without carry only the low tile field advances and wraps
  always_comb begin
    if (carry) nxt = cnt + ONE_W;
    else       nxt = {cnt[W-1:TILE_W], cnt[TILE_W-1:0] + ONE_T};
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= init;
    else if (step) cnt <= nxt;
  end

  // R4: flip inverts the counter output, not the counter itself
  assign coord = flip ? ~cnt : cnt;
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int SRC_W  = 8,
  parameter int SZ_W   = 7,
  parameter int TILE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_go,
  input  logic             tile_carry,
  input  logic [SRC_W-1:0] dst_x,
  input  logic [SRC_W-1:0] dst_y,
  input  logic [SRC_W-1:0] src_x,
  input  logic [SRC_W-1:0] src_y,
  input  logic [SZ_W-1:0]  w_sz,
  input  logic [SZ_W-1:0]  h_sz,
  input  logic             flip_x,
  input  logic             flip_y,
  output logic             busy,
  output logic             iss_v,
  output logic             iss_last,
  output logic [SRC_W-1:0] iss_sx,
  output logic [SRC_W-1:0] iss_sy,
  output logic [SRC_W-1:0] iss_dx,
  output logic [SRC_W-1:0] iss_dy
);
  localparam logic [SZ_W-1:0] SZ_ONE = SZ_W'(1);
  localparam int              PAD_W  = SRC_W - SZ_W;

  logic            active;
  logic            zero_tok;
  logic [SZ_W-1:0] col;
  logic [SZ_W-1:0] row;
  logic            row_end;
  logic            last_row;
  logic            zero_sz;

  assign row_end  = (col == w_sz - SZ_ONE);
  assign last_row = (row == h_sz - SZ_ONE);
  assign zero_sz  = (w_sz == '0) || (h_sz == '0);

  // R3 / R11 / R13: row-major walk; a start always reloads
  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      zero_tok <= 1'b0;
      col      <= '0;
      row      <= '0;
    end else begin
      zero_tok <= start_go && zero_sz;
      if (start_go) begin
        active <= !zero_sz;
        col    <= '0;
        row    <= '0;
      end else if (active) begin
        if (row_end) begin
          col <= '0;
          row <= row + SZ_ONE;
          if (last_row) active <= 1'b0;
        end else begin
          col <= col + SZ_ONE;
        end
      end
    end
  end

  // axis 0 is source X (reloaded per row), axis 1 is source Y
  logic [1:0]            ax_load;
  logic [1:0]            ax_step;
  logic [1:0]            ax_flip;
  logic [1:0][SRC_W-1:0] ax_init;
  logic [1:0][SRC_W-1:0] ax_out;

  assign ax_load[0] = start_go || (active && row_end);
  assign ax_step[0] = active && !row_end;
  assign ax_load[1] = start_go;
  assign ax_step[1] = active && row_end;
  assign ax_flip    = {flip_y, flip_x};
  assign ax_init[0] = src_x;
  assign ax_init[1] = src_y;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    blit_src_axis #(.W(SRC_W), .TILE_W(TILE_W)) u_axis (
      .clk   (clk),
      .rst   (rst),
      .load  (ax_load[a]),
      .step  (ax_step[a]),
      .carry (tile_carry),
      .flip  (ax_flip[a]),
      .init  (ax_init[a]),
      .coord (ax_out[a])
    );
  end

  assign busy     = active;
  assign iss_v    = active;
  assign iss_last = (active && row_end && last_row) || zero_tok;
  assign iss_sx   = ax_out[0];
  assign iss_sy   = ax_out[1];
  assign iss_dx   = dst_x + {{PAD_W{1'b0}}, col};
  assign iss_dy   = dst_y + {{PAD_W{1'b0}}, row};

  // R1: a copy begins only on a real start
  a_r1_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_go));
endmodule

// File: rtl/blit_pixel_pipe.sv
module blit_pixel_pipe #(
  parameter int SRC_W  = 8,
  parameter int DST_W  = 7,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int SA_W  = PAGE_W + 2 * SRC_W,
  localparam int FA_W  = 1 + 2 * DST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic              iss_v,
  input  logic              iss_last,
  input  logic [SRC_W-1:0]  iss_sx,
  input  logic [SRC_W-1:0]  iss_sy,
  input  logic [SRC_W-1:0]  iss_dx,
  input  logic [SRC_W-1:0]  iss_dy,
  input  logic [PAGE_W-1:0] page,
  input  logic              fb_sel,
  input  logic              fill,
  input  logic              opaque,
  input  logic              clip_x,
  input  logic              clip_y,
  input  logic              irq_en,
  input  logic [DATA_W-1:0] color,
  output logic              spr_re,
  output logic [SA_W-1:0]   spr_addr,
  input  logic [DATA_W-1:0] spr_rdata,
  output logic              fb_we,
  output logic [FA_W-1:0]   fb_addr,
  output logic [DATA_W-1:0] fb_wdata,
  output logic              irq
);
  // stage 1: read request out, destination carried alongside (R9)
  logic             s1_last, s1_fb;
  logic [SRC_W-1:0] s1_dx, s1_dy;
  // stage 2: read data arrives
  logic             s2_v, s2_last, s2_fb;
  logic [SRC_W-1:0] s2_dx, s2_dy;

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_re   <= 1'b0;
      spr_addr <= '0;
      s1_last  <= 1'b0;
      s1_fb    <= 1'b0;
      s1_dx    <= '0;
      s1_dy    <= '0;
      s2_v     <= 1'b0;
      s2_last  <= 1'b0;
      s2_fb    <= 1'b0;
      s2_dx    <= '0;
      s2_dy    <= '0;
    end else begin
      spr_re   <= iss_v;
      spr_addr <= {page, iss_sy, iss_sx};
      s1_last  <= iss_last && !kill;
      s1_fb    <= fb_sel;
      s1_dx    <= iss_dx;
      s1_dy    <= iss_dy;
      s2_v     <= spr_re;
      s2_last  <= s1_last && !kill;
      s2_fb    <= s1_fb;
      s2_dx    <= s1_dx;
      s2_dy    <= s1_dy;
    end
  end

  logic [DATA_W-1:0] px;
  logic              out_x, out_y, keep;

  assign px    = fill ? color : spr_rdata;                // R7
  assign out_x = |s2_dx[SRC_W-1:DST_W];                   // R8
  assign out_y = |s2_dy[SRC_W-1:DST_W];
  assign keep  = s2_v && !(clip_x && out_x) && !(clip_y && out_y)
                 && (opaque || (px != '0));               // R6

  // stage 3: registered framebuffer write and completion IRQ (R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
      irq      <= 1'b0;
    end else begin
      fb_we    <= keep;
      fb_addr  <= {s2_fb, s2_dy[DST_W-1:0], s2_dx[DST_W-1:0]};
      fb_wdata <= px;
      if (kill)                    irq <= 1'b0;
      else if (s2_last && irq_en)  irq <= 1'b1;
    end
  end

  a_r6_no_zero_when_transparent: assert property (@(posedge clk) disable iff (rst)
    (fb_we && !$past(opaque)) |-> (fb_wdata != '0));

  a_r7_fill_uses_colour: assert property (@(posedge clk) disable iff (rst)
    (fb_we && $past(fill)) |-> (fb_wdata == $past(color)));
endmodule

// File: rtl/rect_blitter.sv
module rect_blitter #(
  parameter int DATA_W = 8,
  parameter int DST_W  = 7,
  parameter int PAGE_W = 3,
  parameter int TILE_W = 4,
  localparam int SRC_W = DATA_W,
  localparam int SZ_W  = DATA_W - 1,
  localparam int SA_W  = PAGE_W + 2 * SRC_W,
  localparam int FA_W  = 1 + 2 * DST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fill_mode,
  input  logic              tile_carry,
  input  logic              opaque,
  input  logic              irq_en,
  input  logic              clip_x,
  input  logic              clip_y,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              fb_sel,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              spr_re,
  output logic [SA_W-1:0]   spr_addr,
  input  logic [DATA_W-1:0] spr_rdata,
  output logic              fb_we,
  output logic [FA_W-1:0]   fb_addr,
  output logic [DATA_W-1:0] fb_wdata,
  output logic              busy,
  output logic              irq
);
  import blit_pkg::*;

  logic [DATA_W-1:0] dst_x, dst_y, src_x, src_y, size_w, size_h, color;
  logic              start_wr, start_go;
  logic              iss_v, iss_last;
  logic [SRC_W-1:0]  iss_sx, iss_sy, iss_dx, iss_dy;

  blit_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .dst_x    (dst_x),
    .dst_y    (dst_y),
    .src_x    (src_x),
    .src_y    (src_y),
    .size_w   (size_w),
    .size_h   (size_h),
    .color    (color),
    .start_wr (start_wr),
    .start_go (start_go)
  );

  blit_walker #(.SRC_W(SRC_W), .SZ_W(SZ_W), .TILE_W(TILE_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start_go   (start_go),
    .tile_carry (tile_carry),
    .dst_x      (dst_x),
    .dst_y      (dst_y),
    .src_x      (src_x),
    .src_y      (src_y),
    .w_sz       (size_w[SZ_W-1:0]),
    .h_sz       (size_h[SZ_W-1:0]),
    .flip_x     (size_w[DATA_W-1]),
    .flip_y     (size_h[DATA_W-1]),
    .busy       (busy),
    .iss_v      (iss_v),
    .iss_last   (iss_last),
    .iss_sx     (iss_sx),
    .iss_sy     (iss_sy),
    .iss_dx     (iss_dx),
    .iss_dy     (iss_dy)
  );

  blit_pixel_pipe #(.SRC_W(SRC_W), .DST_W(DST_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .kill      (start_wr),
    .iss_v     (iss_v),
    .iss_last  (iss_last),
    .iss_sx    (iss_sx),
    .iss_sy    (iss_sy),
    .iss_dx    (iss_dx),
    .iss_dy    (iss_dy),
    .page      (page_sel),
    .fb_sel    (fb_sel),
    .fill      (fill_mode),
    .opaque    (opaque),
    .clip_x    (clip_x),
    .clip_y    (clip_y),
    .irq_en    (irq_en),
    .color     (color),
    .spr_re    (spr_re),
    .spr_addr  (spr_addr),
    .spr_rdata (spr_rdata),
    .fb_we     (fb_we),
    .fb_addr   (fb_addr),
    .fb_wdata  (fb_wdata),
    .irq       (irq)
  );

  a_r1_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(en && reg_we && (reg_addr == OFS_START) && reg_wdata[0]));

  a_r3_busy_issues_read: assert property (@(posedge clk) disable iff (rst)
    busy |=> spr_re);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(irq_en));

  a_r10_irq_cleared_by_start: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(en && reg_we && (reg_addr == OFS_START)));
endmodule

// File: tb/sim_rect_blitter.sv
module sim_rect_blitter;
  localparam int DATA_W = 8, PAGE_W = 3, DST_W = 7;
  localparam int SA_W = PAGE_W + 2 * DATA_W;
  localparam int FA_W = 1 + 2 * DST_W;
  localparam int FB_N = 1 << FA_W;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic en, fill, carry, opq, irq_en, clip_x, clip_y, fb_sel;
  logic [PAGE_W-1:0] page;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic spr_re;
  logic [SA_W-1:0] spr_addr;
  logic [7:0] spr_rdata = 8'd0;
  logic fb_we;
  logic [FA_W-1:0] fb_addr;
  logic [7:0] fb_wdata;
  logic busy, irq;

  rect_blitter u0 (
    .clk(clk), .rst(rst), .en(en), .fill_mode(fill), .tile_carry(carry),
    .opaque(opq), .irq_en(irq_en), .clip_x(clip_x), .clip_y(clip_y),
    .page_sel(page), .fb_sel(fb_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .spr_re(spr_re), .spr_addr(spr_addr),
    .spr_rdata(spr_rdata), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_wdata(fb_wdata), .busy(busy), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [7:0] fb [FB_N];
  logic [7:0] exp_fb [FB_N];
  logic [7:0] p_vx, p_vy, p_gx, p_gy, p_w, p_h, p_col;

  // sprite content: arithmetic, with a zero every eighth source column
  function automatic logic [7:0] spr_val(input logic [SA_W-1:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd37 + a[15:8] * 8'd11 + {5'd0, a[18:16]} * 8'd101 + 8'd3;
    if (a[2:0] == 3'd0) v = 8'd0;
    return v;
  endfunction

  // expected source address of pixel (r, c), per R4, R5, R9
  function automatic logic [SA_W-1:0] src_at(input int r, input int c);
    logic [7:0] sx, sy, cc, rr;
    cc = c[7:0]; rr = r[7:0];
    sx = carry ? p_gx + cc : {p_gx[7:4], p_gx[3:0] + cc[3:0]};
    sy = carry ? p_gy + rr : {p_gy[7:4], p_gy[3:0] + rr[3:0]};
    if (p_w[7]) sx = ~sx;
    if (p_h[7]) sy = ~sy;
    return {page, sy, sx};
  endfunction

  // memory models
  always @(posedge clk) if (spr_re) spr_rdata <= spr_val(spr_addr);
  always @(posedge clk) if (fb_we) fb[fb_addr] <= fb_wdata;

  // monitor: busy cycles and read order (R3, R13)
  int mk = 0, bcnt = 0, oerr = 0;
  always @(negedge clk) begin
    if (busy) bcnt++;
    if (spr_re) begin
      if (p_w[6:0] == 7'd0) oerr++;
      else if (spr_addr !== src_at(mk / int'(p_w[6:0]), mk % int'(p_w[6:0]))) oerr++;
      mk++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (a == 3'd6) begin mk = 0; bcnt = 0; oerr = 0; end
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
  endtask

  // expected image per R5..R9
  task automatic model_apply();
    for (int r = 0; r < int'(p_h[6:0]); r++)
      for (int c = 0; c < int'(p_w[6:0]); c++) begin
        logic [7:0] dx, dy, v;
        dx = p_vx + c[7:0];
        dy = p_vy + r[7:0];
        v  = fill ? p_col : spr_val(src_at(r, c));
        if (!(clip_x && dx[7]) && !(clip_y && dy[7]) && (opq || v != 8'd0))
          exp_fb[{fb_sel, dy[6:0], dx[6:0]}] = v;
      end
  endtask

  task automatic check_image(input string tag);
    int first = -1;
    for (int i = 0; i < FB_N; i++)
      if (fb[i] !== exp_fb[i] && first < 0) first = i;
    if (first < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, int'(fb[first]), int'(exp_fb[first]));
  endtask

  task automatic set_regs(input logic [7:0] vx, vy, gx, gy, w, h, col);
    p_vx = vx; p_vy = vy; p_gx = gx; p_gy = gy; p_w = w; p_h = h; p_col = col;
    reg_wr(3'd0, vx); reg_wr(3'd1, vy); reg_wr(3'd2, gx); reg_wr(3'd3, gy);
    reg_wr(3'd4, w);  reg_wr(3'd5, h);  reg_wr(3'd7, col);
  endtask

  task automatic blit(input logic [7:0] vx, vy, gx, gy, w, h, col);
    set_regs(vx, vy, gx, gy, w, h, col);
    model_apply();
    reg_wr(3'd6, 8'd1);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog actual=hung expected=idle");
    finish_run();
  end

  initial begin
    for (int i = 0; i < FB_N; i++) begin fb[i] = 8'hA5; exp_fb[i] = 8'hA5; end
    en = 0; fill = 0; carry = 1; opq = 1; irq_en = 1; clip_x = 0; clip_y = 0;
    fb_sel = 0; page = 3'd2; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    p_vx = 0; p_vy = 0; p_gx = 0; p_gy = 0; p_w = 0; p_h = 0; p_col = 0;
    repeat (4) @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(!busy && !irq && !spr_re && !fb_we, "R14 reset outputs low",
        int'({busy, irq, spr_re, fb_we}), 0);

    en = 1;
    blit(8'd5, 8'd7, 8'd16, 8'd32, 8'd10, 8'd5, 8'd0);
    chk(bcnt == 50, "R3 busy cycles", bcnt, 50);
    chk(oerr == 0 && mk == 50, "R13 row-major reads", oerr * 1000 + mk, 50);
    check_image("R9 basic image");
    chk(irq == 1'b1, "R10 irq raised on completion", int'(irq), 1);

    reg_wr(3'd6, 8'd0);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R2 zero write clears irq", int'(irq), 0);
    chk(!busy && bcnt == 0, "R2 zero write starts nothing", bcnt, 0);

    model_apply();
    reg_wr(3'd6, 8'd1);
    wait_idle();
    chk(bcnt == 50 && irq, "R12 repeat by start only", bcnt, 50);
    check_image("R12 repeat image");

    en = 0;
    reg_wr(3'd0, 8'd77);
    reg_wr(3'd6, 8'd1);
    repeat (3) @(negedge clk);
    chk(!busy && bcnt == 0, "R1 start ignored while disabled", bcnt, 0);
    chk(irq == 1'b1, "R1 disabled write keeps irq", int'(irq), 1);
    en = 1; fb_sel = 1;
    model_apply();
    reg_wr(3'd6, 8'd1);
    wait_idle();
    check_image("R1 disabled dest write ignored");

    reg_wr(3'd6, 8'd0);
    p_w = 8'd0;
    reg_wr(3'd4, 8'd0);
    reg_wr(3'd6, 8'd1);
    wait_idle();
    chk(bcnt == 0 && mk == 0, "R3 zero size copies nothing", bcnt + mk, 0);
    chk(irq == 1'b1, "R3 zero size still completes", int'(irq), 1);
    check_image("R3 zero size image");

    set_regs(8'd30, 8'd40, 8'd3, 8'd9, 8'd20, 8'd10, 8'd0);
    model_apply();
    reg_wr(3'd6, 8'd1);
    repeat (30) @(negedge clk);
    reg_wr(3'd6, 8'd1);
    wait_idle();
    chk(bcnt == 200, "R11 restart busy length", bcnt, 200);
    check_image("R11 restart image");

    irq_en = 0;
    blit(8'd60, 8'd2, 8'd40, 8'd41, 8'd4, 8'd4, 8'd0);
    chk(irq == 1'b0, "R10 no irq when disabled", int'(irq), 0);
    irq_en = 1;

    carry = 0;
    blit(8'd2, 8'd90, 8'h1C, 8'h2E, 8'd24, 8'd5, 8'd0);
    chk(oerr == 0 && mk == 120, "R5 tile repeat reads", oerr * 1000 + mk, 120);
    check_image("R5 tile repeat image");
    carry = 1;

    blit(8'd40, 8'd60, 8'h80, 8'h70, 8'h8C, 8'h86, 8'd0);
    chk(oerr == 0 && mk == 72, "R4 flipped reads", oerr * 1000 + mk, 72);
    check_image("R4 flipped image");

    fill = 1;
    blit(8'd70, 8'd70, 8'd0, 8'd0, 8'd16, 8'd8, 8'hEE);
    check_image("R7 fill colour");
    fill = 0; opq = 0;
    blit(8'd70, 8'd70, 8'd8, 8'd5, 8'd16, 8'd8, 8'd0);
    check_image("R6 zero bytes skipped");
    opq = 1;

    clip_x = 1;
    blit(8'd120, 8'd124, 8'd50, 8'd60, 8'd20, 8'd10, 8'd0);
    check_image("R8 clip x and wrap y");
    clip_x = 0; clip_y = 1;
    blit(8'd250, 8'd122, 8'd51, 8'd61, 8'd12, 8'd12, 8'd0);
    check_image("R8 wrap x and clip y");
    clip_y = 0;

    page = 3'd5; fb_sel = 1;
    blit(8'd10, 8'd100, 8'd200, 8'd150, 8'd9, 8'd7, 8'd0);
    chk(oerr == 0 && mk == 63, "R9 page in read address", oerr * 1000 + mk, 63);
    check_image("R9 page and buffer select");

    for (int i = 0; i < 128; i++) begin
      logic [6:0] f;
      int w, h;
      f = i[6:0];
      fill = f[0]; carry = f[1]; opq = f[2]; clip_x = f[3]; clip_y = f[4];
      page = 3'((i * 3) % 8); fb_sel = f[0] ^ f[3]; irq_en = f[1] ^ f[4];
      w = 1 + (i * 13) % 30;
      h = 1 + (i * 7) % 20;
      blit(8'((i * 29 + 100) % 256), 8'((i * 41 + 110) % 256),
           8'((i * 11 + 10) % 256), 8'((i * 23 + 240) % 256),
           {f[5], 7'(w)}, {f[6], 7'(h)}, (i % 16 == 4) ? 8'd0 : 8'(i * 5 + 1));
      chk(oerr == 0 && mk == w * h, "R13 sweep read order", oerr * 1000 + mk, w * h);
      check_image("R4/R5/R6/R7/R8/R9 sweep image");
      chk(irq == irq_en, "R10 sweep irq", int'(irq), int'(irq_en));
    end

    finish_run();
  end
endmodule